// File: doc/BRIEF.md
# 3x3 Hit Cluster Selector

This block sits in a pixel readout chain after the frame-difference and bit-reduction stages. It takes one 8-bit signed difference pixel per valid cycle, in raster order (left to right, then top to bottom), and decides for each pixel whether it is a hit by comparing it against a programmable threshold. For every hit it sends out the 3x3 neighbourhood centred on the hit, followed by one beat carrying the hit's row and column. Pixels that are not part of any hit neighbourhood never leave the block, so the readout sees only a small part of the frame.

Two row-long line buffers give access to the current row and the two rows before it. A 3x3 register window shifts one column for each accepted pixel. The window centre trails the incoming pixel by one row and one column. Hits wait in a small queue of pending clusters, so a burst in progress is never interrupted. Frame width, frame height and queue depth are parameters.

Top module: `cluster_select`

## Requirements
- R1: After reset, out_valid and ovf are 0, and no beat appears until a hit has been detected.
- R2: A pixel is a hit when its value, read as two's complement, is strictly greater than thresh, also read as two's complement. A pixel equal to thresh is not a hit.
- R3: Each hit produces exactly ten consecutive out_valid beats. The first nine have out_coord=0 and carry the neighbourhood in row-major order from the top-left neighbour: upper row left to right, then the hit row, then the lower row. The tenth beat has out_coord=1 and carries the hit position on out_row and out_col.
- R4: Neighbour positions above row 0, left of column 0 or right of column W-1 are emitted as 0.
- R5: Nothing is emitted for pixels that belong to no hit neighbourhood. A frame without hits produces no beats.
- R6: Clusters leave in raster order of their hit pixels. Every pixel can be a hit centre except those in the bottom row and the last pixel of the row above it, because no later pixel of the frame completes their window.
- R7: A pixel accepted with in_sof=1 takes position row 0, column 0, whatever came before it. After the last pixel of a frame the position wraps to (0,0).
- R8: Cycles with in_valid=0 are ignored. in_pix and in_sof then change neither the position, the window nor the line buffers.
- R9: Up to QD pending hits wait in a queue. A hit that finds the queue full and no slot freed in that cycle is dropped and sets ovf. ovf then stays 1 until reset.
- R10: Once a cluster has started, out_valid stays high until its coordinate beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel on in_pix is accepted this cycle |
| in_sof | input | 1 | Accepted pixel is the first of a frame |
| in_pix | input | 8 | Signed difference pixel |
| thresh | input | 8 | Signed hit threshold |
| out_valid | output | 1 | Output beat present |
| out_coord | output | 1 | Beat is the coordinate beat of a cluster |
| out_pix | output | 8 | Neighbourhood pixel on pixel beats |
| out_row | output | $clog2(H) | Hit row, meaningful on the coordinate beat |
| out_col | output | $clog2(W) | Hit column, meaningful on the coordinate beat |
| ovf | output | 1 | Sticky flag: a hit was dropped |

## Verification
The assertions check the framing of every burst on every cycle: nine pixel beats and then one coordinate beat, with no gap inside a burst. They also check that reported coordinates stay inside the range of possible centres, that ovf never falls without a reset, and that clusters in row 0 start with three zero beats. The bench's scenarios are needed for the rest, because these depend on frame contents: the signed compare at and around the threshold, the masking at the left and right edges, the pixels that can never be centres, restart on in_sof in mid-frame, ignored idle cycles, and the dropping of hits when the queue is full. Each is shown by comparing the output stream with clusters that the bench computes from the frame it sends.

// File: rtl/cluster_select.sv
module cluster_select #(
  parameter int W  = 8,
  parameter int H  = 6,
  parameter int QD = 4,
  localparam int CW = $clog2(W),
  localparam int RW = $clog2(H),
  localparam int QA = (QD > 1) ? $clog2(QD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic [7:0]    in_pix,
  input  logic [7:0]    thresh,
  output logic          out_valid,
  output logic          out_coord,
  output logic [7:0]    out_pix,
  output logic [RW-1:0] out_row,
  output logic [CW-1:0] out_col,
  output logic          ovf
);

  logic [CW-1:0] nc, pc, cc;
  logic [RW-1:0] nr, pr, cr;
  logic          first, ev, mt, ml, mr, hit;

  assign pc    = in_sof ? '0 : nc;
  assign pr    = in_sof ? '0 : nr;
  assign first = (pc == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nc <= '0;
      nr <= '0;
    end else if (in_valid) begin
      if (pc == CW'(W - 1)) begin
        nc <= '0;
        nr <= (pr == RW'(H - 1)) ? '0 : pr + RW'(1);
      end else begin
        nc <= pc + CW'(1);
        nr <= pr;
      end
    end
  end

  logic [7:0] lb1 [W];
  logic [7:0] lb2 [W];
  logic [7:0] w   [3][3];

  always_ff @(posedge clk) begin
    if (in_valid) begin
      lb1[pc] <= in_pix;
      lb2[pc] <= lb1[pc];
      for (int i = 0; i < 3; i++) begin
        w[i][0] <= w[i][1];
        w[i][1] <= w[i][2];
      end
      w[0][2] <= lb2[pc];
      w[1][2] <= lb1[pc];
      w[2][2] <= in_pix;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev <= 1'b0;
      cr <= '0;
      cc <= '0;
    end else begin
      ev <= in_valid && (first ? (pr >= RW'(2)) : (pr >= RW'(1)));
      if (in_valid) begin
        cr <= first ? pr - RW'(2) : pr - RW'(1);
        cc <= first ? CW'(W - 1) : pc - CW'(1);
      end
    end
  end

  assign mt  = (cr == '0);
  assign ml  = (cc == '0);
  assign mr  = (cc == CW'(W - 1));
  assign hit = ev && ($signed(w[1][1]) > $signed(thresh));

  logic [71:0] clus;
  always_comb begin
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        clus[8*(3*i+j) +: 8] = ((i == 0 && mt) || (j == 0 && ml) || (j == 2 && mr))
                               ? 8'd0 : w[i][j];
  end

  logic [71:0]   qp [QD];
  logic [RW-1:0] qr [QD];
  logic [CW-1:0] qc [QD];
  logic [QA-1:0] wp, rp;
  logic [QA:0]   cnt;
  logic          full, emp, push, pop, busy;
  logic [3:0]    beat;
  logic [71:0]   cur_p;
  logic [RW-1:0] cur_r;
  logic [CW-1:0] cur_c;

  assign full = (cnt == (QA+1)'(QD));
  assign emp  = (cnt == '0);
  assign pop  = !emp && (!busy || beat == 4'd9);
  assign push = hit && (!full || pop);

  always_ff @(posedge clk) begin
    if (push) begin
      qp[wp] <= clus;
      qr[wp] <= cr;
      qc[wp] <= cc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push) wp <= (wp == QA'(QD - 1)) ? '0 : wp + QA'(1);
      if (pop)  rp <= (rp == QA'(QD - 1)) ? '0 : rp + QA'(1);
      cnt <= cnt + (QA+1)'(push) - (QA+1)'(pop);
      if (hit && full && !pop) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      beat  <= '0;
      cur_p <= '0;
      cur_r <= '0;
      cur_c <= '0;
    end else if (pop) begin
      busy  <= 1'b1;
      beat  <= '0;
      cur_p <= qp[rp];
      cur_r <= qr[rp];
      cur_c <= qc[rp];
    end else if (busy) begin
      if (beat == 4'd9) busy <= 1'b0;
      else              beat <= beat + 4'd1;
    end
  end

  always_comb begin
    out_pix = 8'd0;
    for (int k = 0; k < 9; k++)
      if (busy && beat == 4'(k)) out_pix = cur_p[8*k +: 8];
  end

  assign out_valid = busy;
  assign out_coord = busy && (beat == 4'd9);
  assign out_row   = cur_r;
  assign out_col   = cur_c;

endmodule

// File: rtl/cluster_select_chk.sv
module cluster_select_chk #(
  parameter int W = 8,
  parameter int H = 6,
  localparam int CW = $clog2(W),
  localparam int RW = $clog2(H)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_coord,
  input logic [7:0]    out_pix,
  input logic [RW-1:0] out_row,
  input logic [CW-1:0] out_col,
  input logic          ovf
);

  logic [3:0] n;
  logic       tz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n  <= '0;
      tz <= 1'b0;
    end else if (out_valid) begin
      n <= out_coord ? 4'd0 : n + 4'd1;
      if (!out_coord && n == 4'd0)     tz <= (out_pix == 8'd0);
      else if (!out_coord && n < 4'd3) tz <= tz && (out_pix == 8'd0);
    end
  end

  AST_COORD_AFTER_NINE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_coord |-> n == 4'd9); // R3

  AST_NINE_PIXELS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_coord |-> n < 4'd9); // R3

  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_coord |=> out_valid); // R10

  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> n == 4'd0); // R10

  AST_CENTRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_coord |-> out_row <= RW'(H - 2) && out_col <= CW'(W - 1)
      && !(out_row == RW'(H - 2) && out_col == CW'(W - 1))); // R6

  AST_TOP_EDGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_coord && out_row == '0 |-> tz); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R9

endmodule

bind cluster_select cluster_select_chk #(.W(W), .H(H)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_coord(out_coord),
  .out_pix(out_pix), .out_row(out_row), .out_col(out_col), .ovf(ovf)
);

// File: tb/sim_cluster_select.sv
`timescale 1ns/1ps
module sim_cluster_select;
  localparam int W = 8, H = 6, QD = 4;
  localparam int CW = $clog2(W), RW = $clog2(H);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_pix = '0, thresh = '0;
  logic out_valid, out_coord, ovf;
  logic [7:0] out_pix;
  logic [RW-1:0] out_row;
  logic [CW-1:0] out_col;

  always #2.5 clk = ~clk;

  cluster_select #(.W(W), .H(H), .QD(QD)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_pix(in_pix), .thresh(thresh), .out_valid(out_valid),
    .out_coord(out_coord), .out_pix(out_pix), .out_row(out_row),
    .out_col(out_col), .ovf(ovf)
  );

  int checks = 0, errors = 0;
  int exq[$];
  string tq[$];
  bit cmp_en = 1'b1;
  logic [7:0] fr [H][W];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && cmp_en) begin
      int got;
      got = out_coord ? (32'h10000 | (int'(out_row) << 8) | int'(out_col)) : int'(out_pix);
      if (exq.size() == 0) chk(1'b0, "R5 unexpected beat", got, -1);
      else begin
        int e;
        string t;
        e = exq.pop_front();
        t = tq.pop_front();
        chk(got == e, t, got, e);
      end
    end
  end

  // expected clusters from the frame, independent of the design
  task automatic model(logic [7:0] thr, string tag);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        bit centre_ok;
        centre_ok = (r != H - 1) && !(r == H - 2 && c == W - 1);
        if (centre_ok && $signed(fr[r][c]) > $signed(thr)) begin
          for (int di = -1; di <= 1; di++)
            for (int dj = -1; dj <= 1; dj++) begin
              int rr, cc;
              rr = r + di;
              cc = c + dj;
              exq.push_back((rr < 0 || cc < 0 || cc >= W) ? 0 : int'(fr[rr][cc]));
              tq.push_back(tag);
            end
          exq.push_back(32'h10000 | (r << 8) | c);
          tq.push_back(tag);
        end
      end
  endtask

  task automatic send(bit gap);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (r == 0 && c == 0);
        in_pix   = fr[r][c];
        if (gap) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_sof   = 1'b1;
          in_pix   = 8'h7F;
        end
      end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 3000 && exq.size() != 0; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(exq.size() == 0, tag, exq.size(), 0);
  endtask

  task automatic background();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) fr[r][c] = 8'((r * W + c) % 16);
  endtask

  initial begin
    #1000000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(ovf == 1'b0, "R1 ovf after reset", ovf, 0);

    // no hits at all: nothing must come out
    background();
    thresh = 8'd20;
    send(1'b0);
    drain("R5 quiet frame");

    // single interior hit with distinct neighbours
    background();
    fr[2][3] = 8'd50;
    model(8'd20, "R3 interior cluster");
    send(1'b0);
    drain("R3 interior drain");

    // threshold equality, edges and non-centre positions
    background();
    fr[0][0] = 8'd21; fr[0][7] = 8'd30; fr[3][0] = 8'd40;
    fr[2][7] = 8'd20; fr[4][7] = 8'd90; fr[5][2] = 8'd90; fr[4][3] = 8'd25;
    model(8'd20, "R4 R6 edges and order");
    send(1'b0);
    drain("R6 edge drain");

    // signed compare, idle cycles with junk between pixels
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) fr[r][c] = 8'h80;
    fr[1][1] = 8'hFE; fr[1][5] = 8'hFB; fr[3][4] = 8'h7F; fr[2][6] = 8'hFA;
    thresh = 8'hFB;
    model(8'hFB, "R2 R8 signed with gaps");
    send(1'b1);
    drain("R8 gap drain");

    // restart in mid-frame
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b1; in_sof = (k == 0); in_pix = 8'd120;
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0;
    background();
    fr[1][0] = 8'd60; fr[3][6] = 8'd70;
    thresh = 8'd20;
    model(8'd20, "R7 restart on sof");
    send(1'b0);
    drain("R7 restart drain");
    chk(ovf == 1'b0, "R9 ovf low with sparse hits", ovf, 0);

    // every pixel a hit: queue overflows
    cmp_en = 1'b0;
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) fr[r][c] = 8'd100;
    thresh = 8'd0;
    send(1'b0);
    repeat (600) @(negedge clk);
    chk(ovf == 1'b1, "R9 ovf set", ovf, 1);
    chk(out_valid == 1'b0, "R9 queue drained", out_valid, 0);
    background();
    thresh = 8'd20;
    send(1'b0);
    repeat (40) @(negedge clk);
    chk(ovf == 1'b1, "R9 ovf sticky", ovf, 1);
    cmp_en = 1'b1;

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ovf == 1'b0, "R1 ovf cleared by reset", ovf, 0);
    chk(out_valid == 1'b0, "R1 idle after reset", out_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule